// File: doc/BRIEF.md
# Character Display Command and Address Unit

This block models the command-processing side of a character-matrix display controller. A host drives one transaction per strobe: a register-select bit separates instructions from data, a direction bit separates writes from reads, and an 8-bit byte carries the payload. The unit decodes the instruction byte by its highest set bit. It keeps a 7-bit address counter, the entry and display flags, the display-window shift offset and the interface and line configuration. It also holds two small internal memories: a 128-byte display-data store and a 64-byte glyph store.

One address counter serves both memories. The most recent address-set instruction decides which memory later data reads and writes use. Each accepted access starts a busy interval whose length depends on what ran. The interval is counted in clock cycles derived from the `CLK_HZ` parameter. A status read may be made at any time, even while busy. It returns the busy flag and the address counter. Any other access made while busy is dropped, and the error output pulses. Pixel scan, segment drive and glyph ROM are outside this block.

Top module: `lcd_cmd_unit`

## Requirements
- R1: An instruction byte (select=0, write) is decoded by its highest set bit: 0x01 clear; 0x02/0x03 home; 0000_01IS entry mode (bit1 I: 1 step up, bit0 S: shift on write); 0000_1DCB display/cursor/blink; 0001_SR-- shift (bit3 S: 1 window, 0 cursor; bit2 R: 1 right); 001D_NF-- function (bit4 8-bit bus, bit3 two lines, bit2 tall font); 01aa_aaaa glyph address; 1aaa_aaaa display address.
- R2: A glyph-address set selects the glyph store and loads the counter with a 6-bit address and bit 6 cleared. A display-address set selects the display store with a 7-bit address. Data accesses go to the store selected last.
- R3: Each accepted data read or write moves the counter by +1 when I=1 and by -1 when I=0.
- R4: The counter wraps as follows. In the display store with two lines: up 0x27→0x40 and 0x67→0x00; down 0x40→0x27 and 0x00→0x67. In the display store with one line: up 0x4F→0x00; down 0x00→0x4F. In the glyph store, the counter wraps modulo 64.
- R5: A status read (select=0, read) is accepted even while busy. It returns {busy, counter[6:0]} on the data output one cycle after the strobe and changes no state.
- R6: Busy rises one cycle after an accepted access and stays high for a set number of cycles: 1.64 ms for clear and home, 120 µs for a glyph-store data access, and 40 µs for everything else.
- R7: Clear fills the display store with 0x20, zeroes the counter and the shift offset, forces I=1 and selects the display store.
- R8: Home zeroes the counter and the shift offset, selects the display store and leaves the display store contents unchanged.
- R9: A shift instruction with S=1 moves the offset +1 (right) or -1 (left), modulo 40, and leaves the counter unchanged. With S=0 it steps the counter right (+1) or left (-1) under the R4 wrap rules.
- R10: A display-store data write with entry shift set moves the offset -1 when I=1 and +1 when I=0. Data reads never move the offset.
- R11: The display, cursor, blink, entry, bus-width, line and font flags appear on output pins. After reset: all display flags 0, I=1, S=0, 8-bit bus, one line, short font, offset 0, counter 0.
- R12: A transaction other than a status read that arrives while busy is ignored, and the error output pulses for one cycle after it.
- R13: A data read returns the byte at the counter from the selected store, one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | One-cycle transaction strobe |
| busSel | input | 1 | 1 = data, 0 = instruction/status |
| busRead | input | 1 | 1 = read, 0 = write |
| busWrData | input | 8 | Write byte |
| busRdData | output | 8 | Read result (status or store byte) |
| busy | output | 1 | Busy flag |
| errOut | output | 1 | Pulse: access dropped while busy |
| dispOn | output | 1 | Display enable flag |
| cursorOn | output | 1 | Cursor flag |
| blinkOn | output | 1 | Blink flag |
| entryInc | output | 1 | Entry direction I |
| entryShift | output | 1 | Entry shift S |
| busWide | output | 1 | 8-bit bus flag |
| twoLine | output | 1 | Two-line flag |
| tallFont | output | 1 | Tall font flag |
| shiftOff | output | 6 | Display window offset, 0..39 |

## Verification
The hardest situations to reach are the counter wrap points and a write that lands inside a busy window. The wrap points are reached by setting the address directly to each edge value, then making a data access in each direction and under each line mode. The status read then exposes the counter. A dropped write is produced by a transaction issued on the cycle right after an accepted one, without waiting for busy to fall. A status read after the busy window shows that the dropped address load had no effect.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef struct packed {
    logic statusRd;
    logic doClear;
    logic doHome;
    logic setEntry;
    logic setDisp;
    logic doShift;
    logic setFunc;
    logic setCg;
    logic setDd;
    logic dataWr;
    logic dataRd;
  } lcdStb_t;
endpackage

// File: rtl/lcd_ctrl.sv
module lcd_ctrl
  import lcd_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busSel,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              inCg,
  output lcdStb_t           stb,
  output logic              busy,
  output logic              errOut
);
  localparam int LONG_CYC  = (CLK_HZ / 1000) * 164 / 100;
  localparam int SHORT_CYC = (CLK_HZ / 1000000) * 40;
  localparam int CG_CYC    = (CLK_HZ / 1000000) * 120;
  localparam int CNT_W     = $clog2(LONG_CYC + 1);

  logic [CNT_W-1:0] busyCnt;
  logic             isStatus;
  logic             accept;
  logic             reject;
  logic [CNT_W-1:0] loadCnt;

  assign busy     = (busyCnt != '0);
  assign isStatus = busValid && !busSel && busRead;
  assign accept   = busValid && !isStatus && !busy;
  assign reject   = busValid && !isStatus && busy;

  always_comb begin
    stb          = '0;
    stb.statusRd = isStatus;
    if (accept) begin
      if (busSel) begin
        stb.dataWr = !busRead;
        stb.dataRd = busRead;
      end else if (busWrData[7])           stb.setDd    = 1'b1;
      else if (busWrData[6])               stb.setCg    = 1'b1;
      else if (busWrData[5])               stb.setFunc  = 1'b1;
      else if (busWrData[4])               stb.doShift  = 1'b1;
      else if (busWrData[3])               stb.setDisp  = 1'b1;
      else if (busWrData[2])               stb.setEntry = 1'b1;
      else if (busWrData[1])               stb.doHome   = 1'b1;
      else if (busWrData[0])               stb.doClear  = 1'b1;
    end
  end

  always_comb begin
    if (stb.doClear || stb.doHome)
      loadCnt = CNT_W'(LONG_CYC);
    else if ((stb.dataWr || stb.dataRd) && inCg)
      loadCnt = CNT_W'(CG_CYC);
    else
      loadCnt = CNT_W'(SHORT_CYC);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      errOut  <= 1'b0;
    end else begin
      errOut <= reject;
      if (accept && (busWrData != '0 || busSel))
        busyCnt <= loadCnt;
      else if (busy)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  // R6: an accepted instruction or data access raises busy on the next cycle
  p_busy_after_cmd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (busSel || busWrData != '0)) |=> busy);
  // R12: a dropped access is flagged on the following cycle
  p_reject_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !isStatus && busy) |=> errOut);
  // R12: the error flag never appears without a busy window before it
  p_err_needs_busy_r12: assert property (@(posedge clk) disable iff (!rstN)
    errOut |-> $past(busy));
  // R5: a status read never starts a busy window on its own
  p_status_no_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    (isStatus && !busy) |=> !busy);
endmodule

// File: rtl/lcd_datapath.sv
module lcd_datapath
  import lcd_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int AC_W       = 7,
  parameter int CG_AW      = 6,
  parameter int SHIFT_SPAN = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  lcdStb_t           stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busyIn,
  output logic [DATA_W-1:0] rdData,
  output logic              inCg,
  output logic              dispOn,
  output logic              cursorOn,
  output logic              blinkOn,
  output logic              entryInc,
  output logic              entryShift,
  output logic              busWide,
  output logic              twoLine,
  output logic              tallFont,
  output logic [5:0]        shiftOff
);
  localparam int DD_DEPTH = 1 << AC_W;
  localparam int CG_DEPTH = 1 << CG_AW;
  localparam logic [AC_W-1:0] L1_END   = AC_W'(8'h27);
  localparam logic [AC_W-1:0] L2_START = AC_W'(8'h40);
  localparam logic [AC_W-1:0] L2_END   = AC_W'(8'h67);
  localparam logic [AC_W-1:0] ONE_END  = AC_W'(8'h4F);
  localparam logic [5:0]      OFF_MAX  = 6'(SHIFT_SPAN - 1);
  localparam logic [DATA_W-1:0] BLANK  = DATA_W'(8'h20);

  logic [DATA_W-1:0] ddMem [DD_DEPTH];
  logic [DATA_W-1:0] cgMem [CG_DEPTH];
  logic [AC_W-1:0]   acReg;

  function automatic logic [AC_W-1:0] stepAddr(input logic [AC_W-1:0] a,
                                                input logic up, input logic cg,
                                                input logic two);
    logic [CG_AW-1:0] low;
    low = a[CG_AW-1:0];
    if (cg) begin
      low = up ? low + 1'b1 : low - 1'b1;
      return AC_W'(low);
    end
    if (two) begin
      if (up) begin
        if (a >= L2_END)                  return '0;
        if (a >= L1_END && a < L2_START)  return L2_START;
        return a + 1'b1;
      end
      if (a == '0)       return L2_END;
      if (a == L2_START) return L1_END;
      return a - 1'b1;
    end
    if (up) return (a >= ONE_END) ? '0 : a + 1'b1;
    return (a == '0) ? ONE_END : a - 1'b1;
  endfunction

  function automatic logic [5:0] stepOff(input logic [5:0] o, input logic right);
    if (right) return (o >= OFF_MAX) ? 6'd0 : o + 1'b1;
    return (o == 6'd0) ? OFF_MAX : o - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acReg      <= '0;
      inCg       <= 1'b0;
      dispOn     <= 1'b0;
      cursorOn   <= 1'b0;
      blinkOn    <= 1'b0;
      entryInc   <= 1'b1;
      entryShift <= 1'b0;
      busWide    <= 1'b1;
      twoLine    <= 1'b0;
      tallFont   <= 1'b0;
      shiftOff   <= '0;
      rdData     <= '0;
    end else begin
      if (stb.statusRd)
        rdData <= {busyIn, acReg};
      if (stb.doClear) begin
        acReg    <= '0;
        inCg     <= 1'b0;
        shiftOff <= '0;
        entryInc <= 1'b1;
      end
      if (stb.doHome) begin
        acReg    <= '0;
        inCg     <= 1'b0;
        shiftOff <= '0;
      end
      if (stb.setEntry) begin
        entryInc   <= wrData[1];
        entryShift <= wrData[0];
      end
      if (stb.setDisp) begin
        dispOn   <= wrData[2];
        cursorOn <= wrData[1];
        blinkOn  <= wrData[0];
      end
      if (stb.doShift) begin
        if (wrData[3]) shiftOff <= stepOff(shiftOff, wrData[2]);
        else           acReg    <= stepAddr(acReg, wrData[2], inCg, twoLine);
      end
      if (stb.setFunc) begin
        busWide  <= wrData[4];
        twoLine  <= wrData[3];
        tallFont <= wrData[2];
      end
      if (stb.setCg) begin
        inCg  <= 1'b1;
        acReg <= AC_W'(wrData[CG_AW-1:0]);
      end
      if (stb.setDd) begin
        inCg  <= 1'b0;
        acReg <= wrData[AC_W-1:0];
      end
      if (stb.dataWr) begin
        acReg <= stepAddr(acReg, entryInc, inCg, twoLine);
        if (!inCg && entryShift)
          shiftOff <= stepOff(shiftOff, !entryInc);
      end
      if (stb.dataRd) begin
        acReg  <= stepAddr(acReg, entryInc, inCg, twoLine);
        rdData <= inCg ? cgMem[acReg[CG_AW-1:0]] : ddMem[acReg];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.doClear) begin
      for (int i = 0; i < DD_DEPTH; i++) ddMem[i] <= BLANK;
    end else if (stb.dataWr && !inCg) begin
      ddMem[acReg] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.dataWr && inCg)
      cgMem[acReg[CG_AW-1:0]] <= wrData;
  end

  // R2: a glyph-address set selects the glyph store with a 6-bit address
  p_cg_select_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setCg |=> (inCg && acReg == AC_W'($past(wrData[CG_AW-1:0]))));
  // R5: a status read leaves the counter alone
  p_status_no_side_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.statusRd |=> $stable(acReg));
  // R10: data reads never move the display window
  p_read_no_shift_r10: assert property (@(posedge clk) disable iff (!rstN)
    stb.dataRd |=> $stable(shiftOff));
  // R7: clear leaves the counter at zero, stepping upward, in the display store
  p_clear_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.doClear |=> (acReg == '0 && entryInc && !inCg && shiftOff == '0));
  // R9: a window shift leaves the counter unchanged
  p_shift_keeps_ac_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.doShift && wrData[3]) |=> $stable(acReg));
endmodule

// File: rtl/lcd_cmd_unit.sv
module lcd_cmd_unit
  import lcd_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busValid,
  input  logic       busSel,
  input  logic       busRead,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  output logic       busy,
  output logic       errOut,
  output logic       dispOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic       entryInc,
  output logic       entryShift,
  output logic       busWide,
  output logic       twoLine,
  output logic       tallFont,
  output logic [5:0] shiftOff
);
  lcdStb_t stb;
  logic    inCg;

  lcd_ctrl #(.CLK_HZ(CLK_HZ), .DATA_W(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busSel(busSel),
    .busRead(busRead), .busWrData(busWrData), .inCg(inCg),
    .stb(stb), .busy(busy), .errOut(errOut)
  );

  lcd_datapath #(.DATA_W(8), .AC_W(7), .CG_AW(6), .SHIFT_SPAN(40)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData), .busyIn(busy),
    .rdData(busRdData), .inCg(inCg), .dispOn(dispOn), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .entryInc(entryInc), .entryShift(entryShift),
    .busWide(busWide), .twoLine(twoLine), .tallFont(tallFont),
    .shiftOff(shiftOff)
  );
endmodule

// File: tb/lcd_cmd_unit_bench.sv
module lcd_cmd_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busValid = 1'b0;
  logic       busSel = 1'b0;
  logic       busRead = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       busy, errOut, dispOn, cursorOn, blinkOn, entryInc, entryShift;
  logic       busWide, twoLine, tallFont;
  logic [5:0] shiftOff;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lcd_cmd_unit #(.CLK_HZ(1_000_000)) u_lcd_cmd_unit (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busSel(busSel),
    .busRead(busRead), .busWrData(busWrData), .busRdData(busRdData),
    .busy(busy), .errOut(errOut), .dispOn(dispOn), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .entryInc(entryInc), .entryShift(entryShift),
    .busWide(busWide), .twoLine(twoLine), .tallFont(tallFont),
    .shiftOff(shiftOff)
  );

  // {sel, read, byte, doCheck, expected}
  localparam int NV = 33;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0,1'b0,8'h38,1'b0,8'h00},  // R1 function: 8-bit, two lines
    {1'b0,1'b0,8'h0F,1'b0,8'h00},  // R1 display/cursor/blink on
    {1'b0,1'b0,8'h06,1'b0,8'h00},  // entry up
    {1'b0,1'b0,8'h80,1'b0,8'h00},  // DD 0
    {1'b1,1'b0,8'h41,1'b0,8'h00},
    {1'b1,1'b0,8'h42,1'b0,8'h00},
    {1'b0,1'b1,8'h00,1'b1,8'h02},  // R3 counter 2
    {1'b0,1'b0,8'h80,1'b0,8'h00},
    {1'b1,1'b1,8'h00,1'b1,8'h41},  // R13
    {1'b1,1'b1,8'h00,1'b1,8'h42},  // R13
    {1'b0,1'b1,8'h00,1'b1,8'h02},  // R3 reads step too
    {1'b0,1'b0,8'hA7,1'b0,8'h00},  // DD 0x27
    {1'b1,1'b0,8'h55,1'b0,8'h00},
    {1'b0,1'b1,8'h00,1'b1,8'h40},  // R4 0x27 -> 0x40
    {1'b0,1'b0,8'h04,1'b0,8'h00},  // entry down
    {1'b0,1'b0,8'hC0,1'b0,8'h00},
    {1'b1,1'b0,8'h66,1'b0,8'h00},
    {1'b0,1'b1,8'h00,1'b1,8'h27},  // R4 0x40 -> 0x27 down
    {1'b0,1'b0,8'h48,1'b0,8'h00},  // CG 8
    {1'b0,1'b0,8'h06,1'b0,8'h00},
    {1'b1,1'b0,8'h1F,1'b0,8'h00},
    {1'b0,1'b1,8'h00,1'b1,8'h09},  // R2 CG address
    {1'b0,1'b0,8'h7F,1'b0,8'h00},  // CG 63
    {1'b1,1'b0,8'h11,1'b0,8'h00},
    {1'b0,1'b1,8'h00,1'b1,8'h00},  // R4 CG modulo 64
    {1'b0,1'b0,8'h48,1'b0,8'h00},
    {1'b1,1'b1,8'h00,1'b1,8'h1F},  // R2 glyph read back
    {1'b0,1'b0,8'h81,1'b0,8'h00},  // DD 1
    {1'b1,1'b1,8'h00,1'b1,8'h42},  // R2 DD untouched by CG write
    {1'b0,1'b0,8'h14,1'b0,8'h00},  // cursor right
    {1'b0,1'b1,8'h00,1'b1,8'h03},  // R9 cursor +1
    {1'b0,1'b0,8'h10,1'b0,8'h00},  // cursor left
    {1'b0,1'b1,8'h00,1'b1,8'h02}   // R9 cursor -1
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Issue one strobe; returns at the negedge after the capturing edge.
  task automatic strobe(input logic s, input logic r, input logic [7:0] d);
    @(negedge clk);
    busValid = 1'b1; busSel = s; busRead = r; busWrData = d;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic xfer(input logic s, input logic r, input logic [7:0] d);
    strobe(s, r, d);
    waitIdle();
  endtask

  task automatic statusIs(input string req, input logic [7:0] exp);
    strobe(1'b0, 1'b1, 8'h00);
    check(req, busRdData, exp);
  endtask

  task automatic busyLen(input string req, input logic s, input logic r,
                         input logic [7:0] d, input int exp);
    int n;
    strobe(s, r, d);
    n = 0;
    while (busy && n < 5000) begin n++; @(negedge clk); end
    check(req, n, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 flags", {dispOn,cursorOn,blinkOn,entryInc,entryShift,busWide,twoLine,tallFont},
          8'b0001_0100);
    check("R11 offset", shiftOff, 0);
    check("R11 busy", busy, 0);
    statusIs("R5 reset status", 8'h00);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][18], VEC[i][17], VEC[i][16:9]);
      if (VEC[i][8]) check($sformatf("R1 vector %0d", i), busRdData, VEC[i][7:0]);
    end
    check("R11 display flags", {dispOn,cursorOn,blinkOn,twoLine,busWide}, 5'b11111);

    // R6 busy durations
    busyLen("R6 short", 1'b0, 1'b0, 8'h0C, 40);
    busyLen("R6 home", 1'b0, 1'b0, 8'h02, 1640);
    xfer(1'b0, 1'b0, 8'h40);
    busyLen("R6 glyph access", 1'b1, 1'b0, 8'h0E, 120);
    xfer(1'b0, 1'b0, 8'h80);
    busyLen("R6 display write", 1'b1, 1'b0, 8'h33, 40);

    // R12 and R5: dropped write, status while busy
    strobe(1'b0, 1'b0, 8'h80);
    strobe(1'b0, 1'b0, 8'h90);
    check("R12 error pulse", errOut, 1);
    @(negedge clk);
    check("R12 error one cycle", errOut, 0);
    strobe(1'b0, 1'b1, 8'h00);
    check("R5 busy status", busRdData, 8'h80);
    waitIdle();
    statusIs("R12 dropped address ignored", 8'h00);

    // R8 home keeps data, resets offset
    xfer(1'b0, 1'b0, 8'h18);
    check("R9 window left wraps", shiftOff, 39);
    statusIs("R9 window keeps counter", 8'h00);
    xfer(1'b0, 1'b0, 8'h1C);
    xfer(1'b0, 1'b0, 8'h1C);
    check("R9 window right", shiftOff, 1);
    xfer(1'b0, 1'b0, 8'h83);
    xfer(1'b0, 1'b0, 8'h02);
    check("R8 home offset", shiftOff, 0);
    statusIs("R8 home counter", 8'h00);
    xfer(1'b1, 1'b1, 8'h00);
    check("R8 home keeps data", busRdData, 8'h33);

    // R10 entry shift
    xfer(1'b0, 1'b0, 8'h07);
    xfer(1'b1, 1'b0, 8'h61);
    check("R10 write shifts left", shiftOff, 39);
    xfer(1'b1, 1'b1, 8'h00);
    check("R10 read no shift", shiftOff, 39);
    xfer(1'b0, 1'b0, 8'h05);
    xfer(1'b1, 1'b0, 8'h62);
    check("R10 write shifts right", shiftOff, 0);

    // R4 two-line down from 0 and up from 0x67
    xfer(1'b0, 1'b0, 8'h80);
    xfer(1'b1, 1'b0, 8'h70);
    statusIs("R4 0x00 down", 8'h67);
    xfer(1'b0, 1'b0, 8'h06);
    xfer(1'b1, 1'b0, 8'h71);
    statusIs("R4 0x67 up", 8'h00);
    // R4 one line
    xfer(1'b0, 1'b0, 8'h30);
    xfer(1'b0, 1'b0, 8'hCF);
    xfer(1'b1, 1'b0, 8'h72);
    statusIs("R4 one-line 0x4F up", 8'h00);
    xfer(1'b0, 1'b0, 8'h04);
    xfer(1'b1, 1'b0, 8'h73);
    statusIs("R4 one-line 0x00 down", 8'h4F);
    check("R11 one line flag", twoLine, 0);

    // R7 clear
    busyLen("R7 clear busy", 1'b0, 1'b0, 8'h01, 1640);
    check("R7 clear I", entryInc, 1);
    statusIs("R7 clear counter", 8'h00);
    xfer(1'b1, 1'b1, 8'h00);
    check("R7 blank fill", busRdData, 8'h20);
    xfer(1'b0, 1'b0, 8'hCF);
    xfer(1'b1, 1'b1, 8'h00);
    check("R7 blank fill high", busRdData, 8'h20);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule